// File: doc/BRIEF.md
# Mode Aware Restart Sequencer

This block carries out the stack side of a restart (vectored call) for a CPU that runs either in a 16-bit compatibility mode or in a 24-bit address mode. A single-cycle request brings in a 3-bit vector index, the current mode bit, a suffix code, the 24-bit program counter, the memory base byte and both stack pointers. The block then issues its stack writes one byte per cycle. Each write is tagged with the stack it targets and the address it writes.

Once every byte is out, the block updates the short and long stack pointers, the mode bit and the program counter together, and pulses a done flag. Which bytes are pushed, onto which stack, whether a mode marker byte is stored and which mode results all depend on the current mode and the suffix taken together. The busy time follows the cycle budget of each form, so the surrounding pipeline sees the expected latency.

Top module: `restart_seq`

## Requirements
- R1: After synchronous reset, busy, done and wr_en are 0, and pc_out, mode_out, sps_out and spl_out are all 0.
- R2: The jump target low byte is the vector index times 8 (00h to 38h). If the resulting mode is 1, pc_out becomes {0000h, target}. If the resulting mode is 0, pc_out becomes {base, 00h, target}.
- R3: With suffix code 0 (none) or 3 (treated as none), the mode bit is unchanged. In mode 0, PC[15:8] and then PC[7:0] go to the short stack. In mode 1, PC[23:16], PC[15:8] and PC[7:0] go to the long stack in that order.
- R4: With suffix code 1 (short), PC[15:8] and then PC[7:0] go to the short stack. In mode 1, PC[23:16] follows on the long stack. A marker byte comes last on the long stack: 02h from mode 0, 03h from mode 1. The resulting mode is 0.
- R5: With suffix code 2 (long), all return bytes go to the long stack: two bytes from mode 0, three from mode 1, most significant first. They are followed by the marker 02h or 03h, and the resulting mode is 1.
- R6: Every push predecrements its stack pointer. A short-stack write goes to address {base, SPS-1}, wrapping within 16 bits with the base byte unchanged. A long-stack write goes to SPL-1, wrapping within 24 bits. Consecutive writes to the same stack therefore descend by one.
- R7: After completion, sps_out and spl_out equal the input pointers minus the number of bytes pushed onto each stack, modulo 2^16 and 2^24.
- R8: busy stays high for exactly 5 cycles (no suffix, mode 0), 6 cycles (no suffix, mode 1), 8 cycles (short suffix) or 7 cycles (long suffix).
- R9: done is high for exactly one cycle, the first cycle after busy falls. pc_out, mode_out, sps_out and spl_out already hold their new values in that cycle.
- R10: A request raised while busy is ignored. It does not change the write sequence, the duration or the final results.
- R11: wr_en (wr_long = 1 selects the long stack) is asserted only while busy, for exactly one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Restart request, sampled while idle |
| vec_idx | input | 3 | Restart vector index (target = index*8) |
| mode_in | input | 1 | Current mode: 0 compatibility, 1 wide |
| sfx_in | input | 2 | Suffix: 0 none, 1 short, 2 long, 3 as none |
| pc_in | input | 24 | Program counter at the request |
| base_in | input | 8 | Memory base byte |
| sps_in | input | 16 | Short stack pointer |
| spl_in | input | 24 | Long stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Stack byte write strobe |
| wr_long | output | 1 | 1: long stack, 0: short stack |
| wr_addr | output | 24 | Write address |
| wr_data | output | 8 | Write data byte |
| pc_out | output | 24 | Updated program counter |
| mode_out | output | 1 | Updated mode bit |
| sps_out | output | 16 | Updated short stack pointer |
| spl_out | output | 24 | Updated long stack pointer |

## Verification
All eight vectors are swept against every combination of mode and suffix code, including the reserved code 3. This separates the six push layouts, the two marker values and the two forms of target address. Pointers of zero force both stacks to wrap, which shows whether the short-stack borrow leaks into the base byte. A second request raised mid-sequence with altered inputs shows whether the latched operands are protected.

// File: rtl/restart_seq_pkg.sv
package restart_seq_pkg;

  typedef enum logic [1:0] {
    SFX_NONE  = 2'd0,
    SFX_SHORT = 2'd1,
    SFX_LONG  = 2'd2,
    SFX_RSVD  = 2'd3
  } sfx_e;

  typedef enum logic [1:0] {
    SRC_UPPER = 2'd0,
    SRC_MID   = 2'd1,
    SRC_LOW   = 2'd2,
    SRC_MARK  = 2'd3
  } byte_src_e;

  typedef struct packed {
    logic      valid;
    logic      use_long;
    byte_src_e src;
  } push_slot_t;

  localparam int MAX_PUSH = 4;

  function automatic push_slot_t mk(input logic lg, input byte_src_e s);
    push_slot_t r;
    r.valid    = 1'b1;
    r.use_long = lg;
    r.src      = s;
    return r;
  endfunction

  // Slot idx of the push program chosen by mode and suffix.
  function automatic push_slot_t slot_for(input logic mode, input sfx_e sfx, input int idx);
    push_slot_t seq [MAX_PUSH];
    sfx_e       s;
    for (int k = 0; k < MAX_PUSH; k++) seq[k] = '0;
    s = (sfx == SFX_RSVD) ? SFX_NONE : sfx;
    case ({mode, s})
      {1'b0, SFX_NONE}: begin
        seq[0] = mk(1'b0, SRC_MID); seq[1] = mk(1'b0, SRC_LOW);
      end
      {1'b1, SFX_NONE}: begin
        seq[0] = mk(1'b1, SRC_UPPER); seq[1] = mk(1'b1, SRC_MID); seq[2] = mk(1'b1, SRC_LOW);
      end
      {1'b0, SFX_SHORT}: begin
        seq[0] = mk(1'b0, SRC_MID); seq[1] = mk(1'b0, SRC_LOW); seq[2] = mk(1'b1, SRC_MARK);
      end
      {1'b1, SFX_SHORT}: begin
        seq[0] = mk(1'b0, SRC_MID);   seq[1] = mk(1'b0, SRC_LOW);
        seq[2] = mk(1'b1, SRC_UPPER); seq[3] = mk(1'b1, SRC_MARK);
      end
      {1'b0, SFX_LONG}: begin
        seq[0] = mk(1'b1, SRC_MID); seq[1] = mk(1'b1, SRC_LOW); seq[2] = mk(1'b1, SRC_MARK);
      end
      default: begin
        seq[0] = mk(1'b1, SRC_UPPER); seq[1] = mk(1'b1, SRC_MID);
        seq[2] = mk(1'b1, SRC_LOW);   seq[3] = mk(1'b1, SRC_MARK);
      end
    endcase
    return seq[idx];
  endfunction

endpackage

// File: rtl/restart_plan.sv
module restart_plan
  import restart_seq_pkg::*;
#(
  parameter int CYC_Z = 5,
  parameter int CYC_A = 6,
  parameter int CYC_S = 8,
  parameter int CYC_L = 7,
  parameter int CNT_W = 4
) (
  input  logic                        mode,
  input  sfx_e                        sfx,
  output push_slot_t [MAX_PUSH-1:0]   slots,
  output logic [CNT_W-1:0]            npush,
  output logic [CNT_W-1:0]            total,
  output logic                        mode_next
);

  for (genvar i = 0; i < MAX_PUSH; i++) begin : g_slot
    assign slots[i] = slot_for(mode, sfx, i);
  end

  always_comb begin
    npush = '0;
    for (int k = 0; k < MAX_PUSH; k++)
      if (slots[k].valid) npush = npush + 1'b1;
  end

  always_comb begin
    case (sfx)
      SFX_SHORT: begin total = CNT_W'(CYC_S); mode_next = 1'b0; end
      SFX_LONG:  begin total = CNT_W'(CYC_L); mode_next = 1'b1; end
      default:   begin total = mode ? CNT_W'(CYC_A) : CNT_W'(CYC_Z); mode_next = mode; end
    endcase
  end

endmodule

// File: rtl/restart_ptr_unit.sv
module restart_ptr_unit #(
  parameter int BASE_W = 8,
  parameter int SPS_W  = 16,
  parameter int SPL_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SPS_W-1:0]  sps_ld,
  input  logic [SPL_W-1:0]  spl_ld,
  input  logic              push,
  input  logic              push_long,
  input  logic [BASE_W-1:0] base,
  output logic [SPS_W-1:0]  sps_q,
  output logic [SPL_W-1:0]  spl_q,
  output logic [SPL_W-1:0]  push_addr
);

  logic [SPS_W-1:0] sps_dec;
  logic [SPL_W-1:0] spl_dec;

  assign sps_dec   = sps_q - SPS_W'(1);
  assign spl_dec   = spl_q - SPL_W'(1);
  assign push_addr = push_long ? spl_dec : SPL_W'({base, sps_dec});

  always_ff @(posedge clk) begin
    if (rst) begin
      sps_q <= '0;
      spl_q <= '0;
    end else if (load) begin
      sps_q <= sps_ld;
      spl_q <= spl_ld;
    end else if (push) begin
      if (push_long) spl_q <= spl_dec;
      else           sps_q <= sps_dec;
    end
  end

endmodule

// File: rtl/restart_seq.sv
module restart_seq
  import restart_seq_pkg::*;
#(
  parameter int VEC_W  = 3,
  parameter int BASE_W = 8,
  parameter int SPS_W  = 16,
  parameter int PC_W   = 24,
  parameter int CYC_Z  = 5,
  parameter int CYC_A  = 6,
  parameter int CYC_S  = 8,
  parameter int CYC_L  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [VEC_W-1:0]  vec_idx,
  input  logic              mode_in,
  input  logic [1:0]        sfx_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BASE_W-1:0] base_in,
  input  logic [SPS_W-1:0]  sps_in,
  input  logic [PC_W-1:0]   spl_in,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic              wr_long,
  output logic [PC_W-1:0]   wr_addr,
  output logic [BASE_W-1:0] wr_data,
  output logic [PC_W-1:0]   pc_out,
  output logic              mode_out,
  output logic [SPS_W-1:0]  sps_out,
  output logic [PC_W-1:0]   spl_out
);

  localparam int MAX_AB = (CYC_Z > CYC_A) ? CYC_Z : CYC_A;
  localparam int MAX_SL = (CYC_S > CYC_L) ? CYC_S : CYC_L;
  localparam int MAX_CY = (MAX_AB > MAX_SL) ? MAX_AB : MAX_SL;
  localparam int CNT_W  = $clog2(MAX_CY + 1);
  localparam int PIDX_W = $clog2(MAX_PUSH);
  localparam int TPAD_W = BASE_W - VEC_W - 3;
  localparam int MID_W  = PC_W - 2 * BASE_W;

  logic [CNT_W-1:0]      cnt;
  logic                  mode_q;
  sfx_e                  sfx_q;
  logic [VEC_W-1:0]      vec_q;
  logic [PC_W-1:0]       pc_q;
  logic [BASE_W-1:0]     base_q;

  push_slot_t [MAX_PUSH-1:0] slots;
  push_slot_t            cur;
  logic [CNT_W-1:0]      npush;
  logic [CNT_W-1:0]      total;
  logic                  mode_next;
  logic                  accept;
  logic                  pushing;
  logic                  finishing;
  logic [SPS_W-1:0]      sps_w;
  logic [PC_W-1:0]       spl_w;
  logic [PC_W-1:0]       push_addr;
  logic [BASE_W-1:0]     push_byte;
  logic [BASE_W-1:0]     target;

  restart_plan #(
    .CYC_Z(CYC_Z), .CYC_A(CYC_A), .CYC_S(CYC_S), .CYC_L(CYC_L), .CNT_W(CNT_W)
  ) u_plan (
    .mode      (mode_q),
    .sfx       (sfx_q),
    .slots     (slots),
    .npush     (npush),
    .total     (total),
    .mode_next (mode_next)
  );

  assign accept    = !busy && req;
  assign cur       = slots[cnt[PIDX_W-1:0]];
  assign pushing   = busy && (cnt < npush);
  assign finishing = busy && (cnt == total - CNT_W'(1));
  assign target    = {{TPAD_W{1'b0}}, vec_q, 3'b000};

  restart_ptr_unit #(
    .BASE_W(BASE_W), .SPS_W(SPS_W), .SPL_W(PC_W)
  ) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .sps_ld    (sps_in),
    .spl_ld    (spl_in),
    .push      (pushing),
    .push_long (cur.use_long),
    .base      (base_q),
    .sps_q     (sps_w),
    .spl_q     (spl_w),
    .push_addr (push_addr)
  );

  always_comb begin
    case (cur.src)
      SRC_UPPER: push_byte = pc_q[PC_W-1 -: BASE_W];
      SRC_MID:   push_byte = pc_q[2*BASE_W-1 -: BASE_W];
      SRC_LOW:   push_byte = pc_q[BASE_W-1:0];
      default:   push_byte = {{(BASE_W-2){1'b0}}, 1'b1, mode_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      mode_q   <= 1'b0;
      sfx_q    <= SFX_NONE;
      vec_q    <= '0;
      pc_q     <= '0;
      base_q   <= '0;
      wr_en    <= 1'b0;
      wr_long  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      pc_out   <= '0;
      mode_out <= 1'b0;
      sps_out  <= '0;
      spl_out  <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= '0;
        mode_q <= mode_in;
        sfx_q  <= sfx_e'(sfx_in);
        vec_q  <= vec_idx;
        pc_q   <= pc_in;
        base_q <= base_in;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        if (pushing) begin
          wr_en   <= 1'b1;
          wr_long <= cur.use_long;
          wr_addr <= push_addr;
          wr_data <= push_byte;
        end
        if (finishing) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          mode_out <= mode_next;
          pc_out   <= mode_next ? {{(PC_W-BASE_W){1'b0}}, target}
                                : {base_q, {MID_W{1'b0}}, target};
          sps_out  <= sps_w;
          spl_out  <= spl_w;
        end
      end
    end
  end

  // Assertions
  assert_push_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_long_descend_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_long && $past(wr_long))
      |-> (wr_addr == $past(wr_addr) - PC_W'(1)));

  assert_short_descend_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !wr_long && !$past(wr_long))
      |-> ((wr_addr[SPS_W-1:0] == $past(wr_addr[SPS_W-1:0]) - SPS_W'(1)) &&
           (wr_addr[PC_W-1:SPS_W] == $past(wr_addr[PC_W-1:SPS_W]))));

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(pc_out) && $stable(mode_out) && $stable(sps_out) && $stable(spl_out)));

endmodule

// File: tb/restart_seq_tb.sv
module restart_seq_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [2:0]  vec_idx;
  logic        mode_in;
  logic [1:0]  sfx_in;
  logic [23:0] pc_in;
  logic [7:0]  base_in;
  logic [15:0] sps_in;
  logic [23:0] spl_in;
  logic        busy, done, wr_en, wr_long, mode_out;
  logic [23:0] wr_addr, pc_out, spl_out;
  logic [7:0]  wr_data;
  logic [15:0] sps_out;

  int checks = 0;
  int fails  = 0;

  // expected model state
  logic        e_long [4];
  logic [23:0] e_addr [4];
  logic [7:0]  e_data [4];
  int          e_n;
  logic [15:0] s_cur;
  logic [23:0] l_cur;
  logic [7:0]  e_base;

  // observed
  logic        o_long [4];
  logic [23:0] o_addr [4];
  logic [7:0]  o_data [4];

  always #(CLK_P/2) clk = ~clk;

  restart_seq u_dut (
    .clk(clk), .rst(rst), .req(req), .vec_idx(vec_idx), .mode_in(mode_in),
    .sfx_in(sfx_in), .pc_in(pc_in), .base_in(base_in), .sps_in(sps_in),
    .spl_in(spl_in), .busy(busy), .done(done), .wr_en(wr_en), .wr_long(wr_long),
    .wr_addr(wr_addr), .wr_data(wr_data), .pc_out(pc_out), .mode_out(mode_out),
    .sps_out(sps_out), .spl_out(spl_out)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic lg, input logic [7:0] d);
    if (lg) begin
      l_cur = l_cur - 24'd1;
      e_addr[e_n] = l_cur;
    end else begin
      s_cur = s_cur - 16'd1;
      e_addr[e_n] = {e_base, s_cur};
    end
    e_long[e_n] = lg;
    e_data[e_n] = d;
    e_n++;
  endtask

  task automatic run(input logic m, input int sf, input int v, input logic [23:0] pc,
                     input logic [7:0] base, input logic [15:0] sps, input logic [23:0] spl,
                     input bit inject);
    string       tag;
    logic        e_mode;
    logic [23:0] e_pc;
    int          e_cyc, cyc, nw, guard;
    logic [7:0]  tgt;
    // expected values
    e_n = 0; s_cur = sps; l_cur = spl; e_base = base;
    tag = (sf == 1) ? "R4" : (sf == 2) ? "R5" : "R3";
    case (sf)
      1: begin
        put(1'b0, pc[15:8]); put(1'b0, pc[7:0]);
        if (m) put(1'b1, pc[23:16]);
        put(1'b1, m ? 8'h03 : 8'h02);
        e_mode = 1'b0; e_cyc = 8;
      end
      2: begin
        if (m) put(1'b1, pc[23:16]);
        put(1'b1, pc[15:8]); put(1'b1, pc[7:0]);
        put(1'b1, m ? 8'h03 : 8'h02);
        e_mode = 1'b1; e_cyc = 7;
      end
      default: begin
        if (m) begin put(1'b1, pc[23:16]); put(1'b1, pc[15:8]); put(1'b1, pc[7:0]); end
        else begin put(1'b0, pc[15:8]); put(1'b0, pc[7:0]); end
        e_mode = m; e_cyc = m ? 6 : 5;
      end
    endcase
    tgt  = 8'(v * 8);
    e_pc = e_mode ? {16'h0000, tgt} : {base, 8'h00, tgt};
    // stimulus
    @(negedge clk);
    req = 1'b1; vec_idx = 3'(v); mode_in = m; sfx_in = 2'(sf);
    pc_in = pc; base_in = base; sps_in = sps; spl_in = spl;
    @(negedge clk);
    req = 1'b0;
    cyc = 0; nw = 0; guard = 0;
    while (!done && guard < 64) begin
      if (busy) cyc++;
      if (wr_en) begin
        chk("R11", "write outside busy", {31'd0, busy}, 32'd1);
        if (nw < 4) begin o_long[nw] = wr_long; o_addr[nw] = wr_addr; o_data[nw] = wr_data; end
        nw++;
      end
      if (inject && cyc == 2) begin
        req = 1'b1; vec_idx = ~vec_idx; mode_in = ~m; sfx_in = ~sfx_in;
        pc_in = ~pc; sps_in = ~sps; spl_in = ~spl; base_in = ~base;
      end else req = 1'b0;
      @(negedge clk);
      guard++;
    end
    req = 1'b0;
    if (guard >= 64) chk("R9", "watchdog no done", 32'd0, 32'd1);
    chk(tag, "write count", 32'(nw), 32'(e_n));
    for (int k = 0; k < 4; k++) begin
      if (k < e_n && k < nw) begin
        chk(tag, "write stack", {31'd0, o_long[k]}, {31'd0, e_long[k]});
        chk("R6", "write addr", {8'd0, o_addr[k]}, {8'd0, e_addr[k]});
        chk(tag, "write data", {24'd0, o_data[k]}, {24'd0, e_data[k]});
      end
    end
    chk("R8", "busy cycles", 32'(cyc), 32'(e_cyc));
    chk("R2", "pc_out", {8'd0, pc_out}, {8'd0, e_pc});
    chk(tag, "mode_out", {31'd0, mode_out}, {31'd0, e_mode});
    chk("R7", "sps_out", {16'd0, sps_out}, {16'd0, s_cur});
    chk("R7", "spl_out", {8'd0, spl_out}, {8'd0, l_cur});
    if (inject) chk("R10", "pc after ignored req", {8'd0, pc_out}, {8'd0, e_pc});
    @(negedge clk);
    chk("R9", "done width", {31'd0, done}, 32'd0);
    chk("R11", "idle write", {31'd0, wr_en}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; vec_idx = '0; mode_in = 1'b0; sfx_in = '0;
    pc_in = '0; base_in = '0; sps_in = '0; spl_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "wr_en", {31'd0, wr_en}, 32'd0);
    chk("R1", "pc_out", {8'd0, pc_out}, 32'd0);
    chk("R1", "mode_out", {31'd0, mode_out}, 32'd0);
    chk("R1", "sps_out", {16'd0, sps_out}, 32'd0);
    chk("R1", "spl_out", {8'd0, spl_out}, 32'd0);
    // full sweep over mode, suffix code and vector
    for (int m = 0; m < 2; m++)
      for (int sf = 0; sf < 4; sf++)
        for (int v = 0; v < 8; v++)
          run(1'(m), sf, v, {8'hA0 + 8'(v), 8'h5C ^ 8'(sf), 8'h31 + 8'(m)},
              8'h7E, 16'h8000 + 16'(v), 24'h40_2000 - 24'(sf), 1'b0);
    // wrap of both stacks (R6)
    run(1'b1, 1, 5, 24'hC3_B2_A1, 8'h44, 16'h0000, 24'h000000, 1'b0);
    run(1'b0, 2, 2, 24'h11_22_33, 8'h90, 16'h0001, 24'h000001, 1'b0);
    run(1'b0, 0, 7, 24'h66_77_88, 8'hFF, 16'h0000, 24'h000000, 1'b0);
    run(1'b1, 2, 0, 24'hFF_FF_FF, 8'h01, 16'h0000, 24'h000002, 1'b0);
    // requests during busy (R10)
    run(1'b0, 0, 3, 24'h12_34_56, 8'h21, 16'h0100, 24'h001000, 1'b1);
    run(1'b1, 1, 6, 24'h9A_BC_DE, 8'h5A, 16'h0200, 24'h002000, 1'b1);
    run(1'b0, 2, 1, 24'h0F_1E_2D, 8'h3C, 16'h0003, 24'h000003, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule